// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block holds the configuration of a pattern generator in two copies. A pending copy takes every software write, at any time, whether or not a pattern is playing. A live copy drives the generator through a flat output bus. Software moves the pending values into the live copy by setting a commit bit in a dedicated control address. The move does not happen at once. It is held back until the pattern generator reports that it is stopped. All registers are then copied on a single clock edge, so a mode change never lands in the middle of a pattern.

The commit bit reads back as set while a copy is pending and clears on the edge that performs the copy. A one-cycle done pulse marks that edge. Both copies can be read back through a bank-select input. The waveform sample memory and the serial framing are not part of this block.

Top module: `cfg_dbuf_bank`

## Requirements
- R1: Reset loads every pending and live register with its entry in RESET_VAL (register i at bits [i*DATA_W +: DATA_W]) and clears the commit flag. This holds even when a commit is pending at the time of reset.
- R2: A write to address i (0 <= i < NUM_REGS) updates only pending register i on the next edge, whether pattern_running is high or low. The live copy is left unchanged.
- R3: A write to control address NUM_REGS with bit UPD_BIT (default 0) set raises update_armed on the next edge. Reading that address returns the flag in bit UPD_BIT and zeros elsewhere, and returns the same value for both banks. A write there with bit UPD_BIT clear has no effect.
- R4: While update_armed and pattern_running are both high, the live registers hold their values and the flag stays set.
- R5: On the first clock edge where update_armed is high and pattern_running is low, every live register takes its pending value. On that same edge update_armed clears, unless R8 applies. xfer_done is high for exactly the cycle after that edge.
- R6: Without a commit, writes to the pending registers never reach the live registers, however many cycles pass.
- R7: If a pending register is written in the same cycle as a copy, the live register receives the value from before that write, and the pending register keeps the new value.
- R8: If the commit bit is written in the same cycle as a copy, the copy still happens and update_armed stays set. A second copy then follows at the next edge where the generator is stopped.
- R9: Writes to addresses above NUM_REGS change nothing, and reads from them return zero. rd_bank = 0 selects the pending copy and rd_bank = 1 selects the live copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address (NUM_REGS is the control address) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_bank | input | 1 | Read bank select: 0 pending, 1 live |
| rd_data | output | DATA_W | Combinational read data |
| pattern_running | input | 1 | High while the pattern generator is playing |
| update_armed | output | 1 | Commit pending |
| xfer_done | output | 1 | One-cycle pulse after a copy |
| active_regs | output | NUM_REGS*DATA_W | Live register contents to the generator |

## Verification
Two actions can fall on the same edge: the deferred copy into the live registers, and a new bus write. That write can go either to a pending register or to the commit bit. The bench provokes both collisions. It arms a commit while the generator is stopped, then drives the conflicting write in the very next cycle, which is the cycle in which the copy fires. It then judges the outcome through readback of both banks and the flag. The live register must hold the value from before the write, and the pending register must hold the new one. A commit written during the copy must leave the flag set and trigger a second copy one edge later.

// File: rtl/cfg_dbuf_pkg.sv
package cfg_dbuf_pkg;

   typedef enum logic {
      BANK_PENDING = 1'b0,
      BANK_LIVE    = 1'b1
   } bank_sel_e;

   function automatic int ctrl_addr(input int num_regs);
      return num_regs;
   endfunction

endpackage

// File: rtl/cfg_pending_bank.sv
module cfg_pending_bank #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 4,
   parameter logic [NUM_REGS*DATA_W-1:0] RESET_VAL = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [NUM_REGS*DATA_W-1:0] pend_flat
);

   generate
      if (NUM_REGS < 1) begin : g_bad_regs
         $error("cfg_pending_bank: NUM_REGS must be at least 1");
      end
      if ((1 << ADDR_W) <= NUM_REGS) begin : g_bad_addr
         $error("cfg_pending_bank: ADDR_W too small for control address");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
         logic [DATA_W-1:0] q;
         logic              hit;

         assign hit = wr_en && (wr_addr == ADDR_W'(gi));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= RESET_VAL[gi*DATA_W +: DATA_W];
            else if (hit) q <= wr_data;
         end

         assign pend_flat[gi*DATA_W +: DATA_W] = q;

         // R2
         pend_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> (pend_flat[gi*DATA_W +: DATA_W] == $past(wr_data)));
      end
   endgenerate

endmodule

// File: rtl/cfg_live_bank.sv
module cfg_live_bank #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 16,
   parameter logic [NUM_REGS*DATA_W-1:0] RESET_VAL = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       copy_en,
   input  logic [NUM_REGS*DATA_W-1:0] pend_flat,
   output logic [NUM_REGS*DATA_W-1:0] live_flat
);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
         logic [DATA_W-1:0] q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= RESET_VAL[gi*DATA_W +: DATA_W];
            else if (copy_en) q <= pend_flat[gi*DATA_W +: DATA_W];
         end

         assign live_flat[gi*DATA_W +: DATA_W] = q;
      end
   endgenerate

   // R6
   live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !copy_en |=> $stable(live_flat));

   // R5
   live_copy_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy_en |=> (live_flat == $past(pend_flat)));

endmodule

// File: rtl/cfg_commit_ctrl.sv
module cfg_commit_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_req,
   input  logic pattern_running,
   output logic armed,
   output logic copy_en,
   output logic xfer_done
);

   logic armed_q;
   logic armed_d;
   logic done_q;

   assign copy_en = armed_q && !pattern_running;

   always_comb begin
      armed_d = armed_q;
      if (copy_en) armed_d = 1'b0;
      if (arm_req) armed_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         armed_q <= armed_d;
         done_q  <= copy_en;
      end
   end

   assign armed     = armed_q;
   assign xfer_done = done_q;

   // R4
   hold_while_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pattern_running) |=> armed);

   // R8
   rearm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm_req |=> armed);

   // R5
   clear_on_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_en && !arm_req) |=> (!armed && xfer_done));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!copy_en) |=> !xfer_done);

endmodule

// File: rtl/cfg_dbuf_bank.sv
module cfg_dbuf_bank
   import cfg_dbuf_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 16,
   parameter int UPD_BIT  = 0,
   parameter logic [NUM_REGS*DATA_W-1:0] RESET_VAL = '0,
   localparam int ADDR_W  = $clog2(NUM_REGS + 1),
   localparam int FLAT_W  = NUM_REGS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_bank,
   output logic [DATA_W-1:0] rd_data,
   input  logic              pattern_running,
   output logic              update_armed,
   output logic              xfer_done,
   output logic [FLAT_W-1:0] active_regs
);

   localparam int CTRL_ADDR = ctrl_addr(NUM_REGS);

   generate
      if (UPD_BIT < 0 || UPD_BIT >= DATA_W) begin : g_bad_bit
         $error("cfg_dbuf_bank: UPD_BIT outside data word");
      end
   endgenerate

   logic [FLAT_W-1:0] pend_flat;
   logic [FLAT_W-1:0] live_flat;
   logic              arm_req;
   logic              copy_en;
   logic              armed;

   assign arm_req = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)) && wr_data[UPD_BIT];

   cfg_pending_bank #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .RESET_VAL(RESET_VAL)
   ) u_pending (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pend_flat(pend_flat)
   );

   cfg_live_bank #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .RESET_VAL(RESET_VAL)
   ) u_live (
      .clk      (clk),
      .rst_n    (rst_n),
      .copy_en  (copy_en),
      .pend_flat(pend_flat),
      .live_flat(live_flat)
   );

   cfg_commit_ctrl u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .arm_req        (arm_req),
      .pattern_running(pattern_running),
      .armed          (armed),
      .copy_en        (copy_en),
      .xfer_done      (xfer_done)
   );

   always_comb begin
      rd_data = '0;
      if (int'(rd_addr) < NUM_REGS) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
               if (bank_sel_e'(rd_bank) == BANK_LIVE)
                  rd_data = live_flat[i*DATA_W +: DATA_W];
               else
                  rd_data = pend_flat[i*DATA_W +: DATA_W];
            end
         end
      end else if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
         rd_data[UPD_BIT] = armed;
      end
   end

   assign update_armed = armed;
   assign active_regs  = live_flat;

   // R4
   live_frozen_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (update_armed && pattern_running) |=> $stable(active_regs));

   // R1
   reset_clears_flag_chk: assert property (@(posedge clk)
      !rst_n |-> !update_armed);

endmodule

// File: tb/test_cfg_dbuf_bank.sv
`timescale 1ns/1ps
module test_cfg_dbuf_bank;

   localparam int NR = 8;
   localparam int DW = 16;
   localparam int AW = 4;

   function automatic logic [NR*DW-1:0] mk_defaults();
      logic [NR*DW-1:0] v;
      for (int i = 0; i < NR; i++) v[i*DW +: DW] = 16'hA000 + 16'(i);
      return v;
   endfunction
   localparam logic [NR*DW-1:0] DEFS = mk_defaults();

   logic clk = 0;
   logic rst_n = 0;
   logic wr_en = 0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic rd_bank = 0;
   logic [DW-1:0] rd_data;
   logic pattern_running = 0;
   logic update_armed;
   logic xfer_done;
   logic [NR*DW-1:0] active_regs;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   cfg_dbuf_bank #(.NUM_REGS(NR), .DATA_W(DW), .UPD_BIT(0), .RESET_VAL(DEFS)) i_cfg_dbuf_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_bank(rd_bank), .rd_data(rd_data),
      .pattern_running(pattern_running), .update_armed(update_armed),
      .xfer_done(xfer_done), .active_regs(active_regs));

   task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input string req, input logic [AW-1:0] a, input logic b, input logic [DW-1:0] exp);
      rd_addr = a; rd_bank = b;
      #1;
      chk(req, rd_data, exp);
   endtask

   // vector: req[27:24] op[23:22] run[21] bank[20] addr[19:16] data[15:0]
   // op 0 = write, 1 = read and compare, 2 = idle cycle
   localparam int NV = 24;
   localparam logic [27:0] VEC [NV] = '{
      {4'd1, 2'd1, 1'b0, 1'b0, 4'd0, 16'hA000},  // R1 pending reg0
      {4'd1, 2'd1, 1'b0, 1'b1, 4'd3, 16'hA003},  // R1 live reg3
      {4'd1, 2'd1, 1'b0, 1'b0, 4'd8, 16'h0000},  // R1 flag clear
      {4'd2, 2'd0, 1'b1, 1'b0, 4'd2, 16'h1234},  // R2 write while running
      {4'd2, 2'd1, 1'b1, 1'b0, 4'd2, 16'h1234},  // R2 pending updated
      {4'd2, 2'd1, 1'b1, 1'b1, 4'd2, 16'hA002},  // R2 live untouched
      {4'd3, 2'd0, 1'b1, 1'b0, 4'd8, 16'hFFFE},  // R3 commit bit clear
      {4'd3, 2'd1, 1'b1, 1'b0, 4'd8, 16'h0000},  // R3 no arm
      {4'd3, 2'd0, 1'b1, 1'b0, 4'd8, 16'h0001},  // R3 arm
      {4'd3, 2'd1, 1'b1, 1'b1, 4'd8, 16'h0001},  // R3 flag via live bank
      {4'd4, 2'd2, 1'b1, 1'b0, 4'd0, 16'h0000},  // R4 idle while running
      {4'd4, 2'd1, 1'b1, 1'b1, 4'd2, 16'hA002},  // R4 live held
      {4'd4, 2'd1, 1'b1, 1'b0, 4'd8, 16'h0001},  // R4 still armed
      {4'd5, 2'd2, 1'b0, 1'b0, 4'd0, 16'h0000},  // R5 stop: copy fires
      {4'd5, 2'd1, 1'b0, 1'b1, 4'd2, 16'h1234},  // R5 live copied
      {4'd5, 2'd1, 1'b0, 1'b0, 4'd8, 16'h0000},  // R5 flag cleared
      {4'd9, 2'd0, 1'b0, 1'b0, 4'd12, 16'hFFFF}, // R9 out-of-range write
      {4'd9, 2'd1, 1'b0, 1'b0, 4'd12, 16'h0000}, // R9 reads zero
      {4'd9, 2'd1, 1'b0, 1'b0, 4'd8, 16'h0000},  // R9 did not arm
      {4'd6, 2'd0, 1'b0, 1'b0, 4'd1, 16'h0BEE},  // R6 write, no commit
      {4'd6, 2'd2, 1'b0, 1'b0, 4'd0, 16'h0000},  // R6 idle
      {4'd6, 2'd2, 1'b0, 1'b0, 4'd0, 16'h0000},  // R6 idle
      {4'd6, 2'd1, 1'b0, 1'b1, 4'd1, 16'hA001},  // R6 live unchanged
      {4'd6, 2'd1, 1'b0, 1'b0, 4'd1, 16'h0BEE}   // R6 pending holds new
   };

   initial begin
      #(200000 * 5);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;

      for (int k = 0; k < NV; k++) begin
         logic [27:0] v;
         string tag;
         v = VEC[k];
         tag = $sformatf("R%0d vec%0d", v[27:24], k);
         @(negedge clk);
         pattern_running = v[21];
         wr_en = 0;
         case (v[23:22])
            2'd0: begin wr_en = 1; wr_addr = v[19:16]; wr_data = v[15:0]; end
            2'd1: rd(tag, v[19:16], v[20], v[15:0]);
            default: ;
         endcase
      end
      @(negedge clk);
      wr_en = 0;

      // R5 pulse timing and one-edge copy of register 4
      wr(4'd4, 16'h4444);
      @(negedge clk);
      wr_en = 1; wr_addr = 4'd8; wr_data = 16'h0001;
      @(negedge clk);
      wr_en = 0;
      chk("R5 armed before copy", 16'(update_armed), 16'h1);
      chk("R5 no pulse yet", 16'(xfer_done), 16'h0);
      @(negedge clk);
      chk("R5 pulse", 16'(xfer_done), 16'h1);
      chk("R5 flag cleared", 16'(update_armed), 16'h0);
      chk("R5 live reg4", active_regs[4*DW +: DW], 16'h4444);
      @(negedge clk);
      chk("R5 pulse one cycle", 16'(xfer_done), 16'h0);

      // R7 pending write in the copy cycle
      wr(4'd5, 16'h1111);
      @(negedge clk);
      wr_en = 1; wr_addr = 4'd8; wr_data = 16'h0001;
      @(negedge clk);
      wr_addr = 4'd5; wr_data = 16'h2222;
      @(negedge clk);
      wr_en = 0;
      rd("R7 live gets old value", 4'd5, 1'b1, 16'h1111);
      rd("R7 pending keeps new value", 4'd5, 1'b0, 16'h2222);
      chk("R7 flag cleared", 16'(update_armed), 16'h0);

      // R8 commit written in the copy cycle
      wr(4'd6, 16'h3333);
      @(negedge clk);
      wr_en = 1; wr_addr = 4'd8; wr_data = 16'h0001;
      @(negedge clk);
      wr_addr = 4'd8; wr_data = 16'h0001;
      @(negedge clk);
      wr_en = 0;
      chk("R8 copy happened", active_regs[6*DW +: DW], 16'h3333);
      chk("R8 still armed", 16'(update_armed), 16'h1);
      @(negedge clk);
      chk("R8 second copy clears", 16'(update_armed), 16'h0);
      chk("R8 second pulse", 16'(xfer_done), 16'h1);

      // R1 reset while armed
      pattern_running = 1;
      wr(4'd7, 16'h7777);
      wr(4'd8, 16'h0001);
      chk("R1 armed before reset", 16'(update_armed), 16'h1);
      rst_n = 0;
      #1;
      chk("R1 flag cleared by reset", 16'(update_armed), 16'h0);
      rd("R1 pending reg7 default", 4'd7, 1'b0, 16'hA007);
      rd("R1 live reg6 default", 4'd6, 1'b1, 16'hA006);
      @(negedge clk);
      rst_n = 1;
      pattern_running = 0;
      repeat (2) @(negedge clk);
      rd("R1 no copy after reset", 4'd2, 1'b1, 16'hA002);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule